// File: doc/BRIEF.md
# Flash Query Response Formatter

This block produces the read data that a parallel NOR flash bank returns while it sits in identifier-read mode or in table-query mode. The caller gives a bus byte offset, an access size and the active query mode. Three static parameters describe how the bank is built: the bank width, the width at which each device is used, and the widest width the devices support. From these the block scales the offset to device addressing and looks up either a small query table or the two identifier codes. The answer of one device is then copied into every device lane of the bank.

An access wider than the bank is assembled from several bank-wide answers taken at stepped offsets. Bytes beyond the access size read as zero. The table contents and the identifier codes are parameters. One clock after a read strobe the result appears, registered, with a valid flag.

Top module: `qry_resp_fmt`

## Requirements
- R1: While reset is held, `rsp_valid` is 0 and `rsp_data` is all zeros.
- R2: Each cycle with `rd_stb` high gives exactly one cycle of `rsp_valid` high at the next clock edge, with results in strobe order. A cycle without a strobe gives `rsp_valid` low at the next edge.
- R3: The query index is the byte offset shifted right by log2(bank width) + log2(max device width) − log2(device width). With the defaults (2, 1, 2) this is offset >> 2, so the two low offset bits have no effect.
- R4: In table mode, an index of 0x52 or above answers zero. Index 0x51, the last entry, is still read.
- R5: Table mode is `qry_mode`=1. The table holds 0x51, 0x52 and 0x59 at indexes 0x10, 0x11 and 0x12. It holds the command-set code at 0x13, the size exponent at 0x27, the write-buffer exponent at 0x2A, 0x01 at 0x2C and the end marker at 0x51. Every other index holds zero.
- R6: When the device width is below the maximum device width, the table byte fills every byte of the device answer rather than being padded with zeros. This case requires a device width of 1 and a bank width of at most 4; any other mismatched setup answers zero.
- R7: The device answer is repeated into every device-width slot of the bank word, so with byte-wide devices every byte of a bank word is equal.
- R8: Identifier mode is `qry_mode`=0. Only the low 8 bits of the index are decoded: 0 gives the low device-width bytes of the manufacturer code, 1 gives those of the device code, and any other value gives zero.
- R9: For an access wider than the bank, bank word k is queried at offset + k·bank·bank and placed starting at byte k·bank of `rsp_data`.
- R10: The access size is 2^`acc_lg` bytes, capped at the output width. Bytes at or above that size are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | Read strobe; inputs are sampled on this cycle |
| qry_mode | input | 1 | 0 = identifier read, 1 = table query |
| acc_lg | input | 2 | log2 of the access size in bytes |
| byte_off | input | ADDR_W | Bus byte offset of the access |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_data | output | 8*OUT_BYTES | Formatted response, byte 0 in the low bits |

## Verification
Every result is due at the first rising edge after the cycle in which `rd_stb` is sampled high, because the data path has exactly one register. The driver changes inputs on falling edges and pushes the expected word into a queue. The monitor also acts on falling edges, half a cycle after the capture edge, and pops one entry for every `rsp_valid` it sees. A valid with no queued entry is a failure, and so is a queue that is not empty once the stimulus has drained. Back-to-back strobes and isolated strobes are both used, so that the one-cycle latency is checked with and without pipelining.

// File: rtl/qrf_pkg.sv
`timescale 1ns/1ps
package qrf_pkg;

  localparam int unsigned TBL_LEN = 82;

  function automatic int unsigned lg2(input int unsigned v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if ((32'd1 << i) == v) r = i;
    end
    return r;
  endfunction

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // device-address scaling of a bus byte offset
  function automatic logic [31:0] scale_off(input logic [31:0] off, input int unsigned sh);
    return off >> sh;
  endfunction

  // sparse query table; everything not listed is zero
  function automatic logic [7:0] tbl_byte(input logic [31:0] idx,
                                          input logic [7:0] cmdset,
                                          input logic [7:0] size_lg,
                                          input logic [7:0] wbuf_lg,
                                          input logic [7:0] end_mark);
    case (idx)
      32'h10:  return 8'h51;
      32'h11:  return 8'h52;
      32'h12:  return 8'h59;
      32'h13:  return cmdset;
      32'h27:  return size_lg;
      32'h2A:  return wbuf_lg;
      32'h2C:  return 8'h01;
      32'h51:  return end_mark;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/qrf_index.sv
`timescale 1ns/1ps
module qrf_index
  import qrf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned BANK_BYTES = 2,
  parameter int unsigned SHIFT      = 2,
  parameter int unsigned CHUNK      = 0
) (
  input  logic [ADDR_W-1:0] base_off,
  output logic [ADDR_W-1:0] dev_idx
);
  localparam int unsigned STEP = CHUNK * BANK_BYTES * BANK_BYTES;

  logic [ADDR_W-1:0] step_off;
  assign step_off = base_off + ADDR_W'(STEP);
  assign dev_idx  = ADDR_W'(scale_off(32'(step_off), SHIFT));
endmodule

// File: rtl/qrf_dev_word.sv
`timescale 1ns/1ps
module qrf_dev_word
  import qrf_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned BANK_BYTES   = 2,
  parameter int unsigned DEV_BYTES    = 1,
  parameter int unsigned MAXDEV_BYTES = 2,
  parameter logic [7:0]  CMDSET       = 8'h01,
  parameter logic [7:0]  SIZE_LG      = 8'h17,
  parameter logic [7:0]  WBUF_LG      = 8'h0B,
  parameter logic [7:0]  END_MARK     = 8'h3C,
  parameter logic [15:0] MFR_CODE     = 16'h0089,
  parameter logic [15:0] DEV_CODE     = 16'h0018
) (
  input  logic [ADDR_W-1:0]       idx,
  input  logic                    mode_tbl,
  output logic [8*BANK_BYTES-1:0] bank_word
);
  localparam int unsigned NDEV    = BANK_BYTES / DEV_BYTES;
  localparam bit          REDUCED = (DEV_BYTES != MAXDEV_BYTES);
  localparam bit          CFG_BAD = REDUCED && ((DEV_BYTES != 1) || (BANK_BYTES > 4));

  logic [31:0]              idx32;
  logic                     idx_oor;
  logic [7:0]               tbyte;
  logic [8*DEV_BYTES-1:0]   tbl_ans;
  logic [8*DEV_BYTES+15:0]  code_ext;
  logic [8*DEV_BYTES-1:0]   id_ans;
  logic [8*DEV_BYTES-1:0]   dev_ans;

  assign idx32   = 32'(idx);
  assign idx_oor = (idx32 >= TBL_LEN);
  assign tbyte   = idx_oor ? 8'h00 : tbl_byte(idx32, CMDSET, SIZE_LG, WBUF_LG, END_MARK);

  always_comb begin
    tbl_ans = '0;
    if (CFG_BAD)      tbl_ans = '0;
    else if (REDUCED) tbl_ans = {DEV_BYTES{tbyte}};
    else              tbl_ans[7:0] = tbyte;
  end

  always_comb begin
    code_ext = '0;
    case (idx[7:0])
      8'd0:    code_ext[15:0] = MFR_CODE;
      8'd1:    code_ext[15:0] = DEV_CODE;
      default: code_ext = '0;
    endcase
  end
  assign id_ans = code_ext[8*DEV_BYTES-1:0];

  assign dev_ans   = mode_tbl ? tbl_ans : id_ans;
  assign bank_word = {NDEV{dev_ans}};
endmodule

// File: rtl/qry_resp_fmt.sv
`timescale 1ns/1ps
module qry_resp_fmt
  import qrf_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned BANK_BYTES   = 2,
  parameter int unsigned DEV_BYTES    = 1,
  parameter int unsigned MAXDEV_BYTES = 2,
  parameter int unsigned OUT_BYTES    = 4,
  parameter logic [7:0]  CMDSET       = 8'h01,
  parameter logic [7:0]  SIZE_LG      = 8'h17,
  parameter logic [7:0]  WBUF_LG      = 8'h0B,
  parameter logic [7:0]  END_MARK     = 8'h3C,
  parameter logic [15:0] MFR_CODE     = 16'h0089,
  parameter logic [15:0] DEV_CODE     = 16'h0018
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_stb,
  input  logic                   qry_mode,
  input  logic [1:0]             acc_lg,
  input  logic [ADDR_W-1:0]      byte_off,
  output logic                   rsp_valid,
  output logic [8*OUT_BYTES-1:0] rsp_data
);
  localparam int unsigned SHIFT  = lg2(BANK_BYTES) + lg2(MAXDEV_BYTES) - lg2(DEV_BYTES);
  localparam int unsigned NCHUNK = OUT_BYTES / BANK_BYTES;
  localparam int unsigned DW     = 8 * OUT_BYTES;

  if (!is_pow2(BANK_BYTES) || !is_pow2(DEV_BYTES) ||
      !is_pow2(MAXDEV_BYTES) || !is_pow2(OUT_BYTES)) begin : g_bad_pow2
    $error("qry_resp_fmt: width parameters must be powers of two");
  end
  if (DEV_BYTES > BANK_BYTES || MAXDEV_BYTES < DEV_BYTES ||
      OUT_BYTES < BANK_BYTES || ADDR_W < 8 || ADDR_W > 32) begin : g_bad_shape
    $error("qry_resp_fmt: inconsistent width parameters");
  end

  logic [7:0]    acc_bytes;
  logic [DW-1:0] merged;
  logic [DW-1:0] masked;

  always_comb begin
    acc_bytes = 8'd1 << acc_lg;
    if (acc_bytes > 8'(OUT_BYTES)) acc_bytes = 8'(OUT_BYTES);
  end

  for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
    logic [ADDR_W-1:0]       q_idx;
    logic [8*BANK_BYTES-1:0] word;

    qrf_index #(
      .ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES), .SHIFT(SHIFT), .CHUNK(k)
    ) u_idx (
      .base_off(byte_off),
      .dev_idx (q_idx)
    );

    qrf_dev_word #(
      .ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES), .DEV_BYTES(DEV_BYTES),
      .MAXDEV_BYTES(MAXDEV_BYTES), .CMDSET(CMDSET), .SIZE_LG(SIZE_LG),
      .WBUF_LG(WBUF_LG), .END_MARK(END_MARK), .MFR_CODE(MFR_CODE),
      .DEV_CODE(DEV_CODE)
    ) u_dw (
      .idx      (q_idx),
      .mode_tbl (qry_mode),
      .bank_word(word)
    );

    assign merged[k*8*BANK_BYTES +: 8*BANK_BYTES] = word;
  end

  for (genvar b = 0; b < OUT_BYTES; b++) begin : g_mask
    assign masked[8*b +: 8] = (8'(b) < acc_bytes) ? merged[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_stb;
      if (rd_stb) rsp_data <= masked;
    end
  end
endmodule

// File: rtl/qrf_chk.sv
`timescale 1ns/1ps
module qrf_chk
  import qrf_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned BANK_BYTES   = 2,
  parameter int unsigned DEV_BYTES    = 1,
  parameter int unsigned MAXDEV_BYTES = 2,
  parameter int unsigned OUT_BYTES    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_stb,
  input logic                   qry_mode,
  input logic [1:0]             acc_lg,
  input logic [ADDR_W-1:0]      byte_off,
  input logic                   rsp_valid,
  input logic [8*OUT_BYTES-1:0] rsp_data
);
  localparam int unsigned SHIFT = lg2(BANK_BYTES) + lg2(MAXDEV_BYTES) - lg2(DEV_BYTES);

  logic [ADDR_W-1:0] idx0;
  assign idx0 = byte_off >> SHIFT;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && rsp_data == '0));

  // R2
  valid_follows_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rsp_valid);

  // R2
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rsp_valid);

  // R4
  oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && qry_mode && acc_lg == 2'd0 && 32'(idx0) >= TBL_LEN) |=> rsp_data[7:0] == 8'h00);

  // R8
  id_other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !qry_mode && acc_lg == 2'd0 && idx0[7:0] > 8'd1) |=> rsp_data == '0);

  if (OUT_BYTES > 1) begin : g_narrow
    // R10
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && acc_lg == 2'd0) |=> rsp_data[8*OUT_BYTES-1:8] == '0);
  end

  if (BANK_BYTES > 1 && DEV_BYTES == 1) begin : g_lanes
    // R7
    lanes_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && 32'(acc_lg) >= lg2(BANK_BYTES)) |=> rsp_data[15:8] == rsp_data[7:0]);
  end
endmodule

bind qry_resp_fmt qrf_chk #(
  .ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES), .DEV_BYTES(DEV_BYTES),
  .MAXDEV_BYTES(MAXDEV_BYTES), .OUT_BYTES(OUT_BYTES)
) u_qrf_chk (.*);

// File: tb/tb_qry_resp_fmt.sv
`timescale 1ns/1ps
module tb_qry_resp_fmt;
  localparam int unsigned AW = 16, BANK = 2, DEVW = 1, MAXW = 2, OUTB = 4;
  localparam logic [7:0]  K_CMD = 8'h01, K_SIZE = 8'h17, K_WBUF = 8'h0B, K_END = 8'h3C;
  localparam logic [15:0] K_MFR = 16'h0089, K_DEV = 16'h0018;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_stb = 1'b0;
  logic          qry_mode = 1'b0;
  logic [1:0]    acc_lg = 2'd0;
  logic [AW-1:0] byte_off = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_data;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  qry_resp_fmt #(
    .ADDR_W(AW), .BANK_BYTES(BANK), .DEV_BYTES(DEVW), .MAXDEV_BYTES(MAXW),
    .OUT_BYTES(OUTB), .CMDSET(K_CMD), .SIZE_LG(K_SIZE), .WBUF_LG(K_WBUF),
    .END_MARK(K_END), .MFR_CODE(K_MFR), .DEV_CODE(K_DEV)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .qry_mode(qry_mode),
    .acc_lg(acc_lg), .byte_off(byte_off), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] ref_tbl(input int unsigned i);
    if (i == 81) return K_END;
    if (i == 44) return 8'h01;
    if (i == 42) return K_WBUF;
    if (i == 39) return K_SIZE;
    if (i == 19) return K_CMD;
    if (i == 18) return "Y";
    if (i == 17) return "R";
    if (i == 16) return "Q";
    return 8'h00;
  endfunction

  function automatic logic [31:0] ref_data(input bit tbl, input int unsigned lgw,
                                           input int unsigned off);
    logic [31:0] r;
    int unsigned nb, sh;
    r  = '0;
    nb = 1 << lgw;
    if (nb > OUTB) nb = OUTB;
    sh = $clog2(BANK) + $clog2(MAXW) - $clog2(DEVW);
    for (int unsigned b = 0; b < nb; b++) begin
      int unsigned chunk, lane, idx;
      logic [15:0] code;
      logic [7:0]  v;
      chunk = b / BANK;
      lane  = (b % BANK) % DEVW;
      idx   = ((off + chunk * BANK * BANK) % (1 << AW)) >> sh;
      if (tbl) begin
        if (idx >= 82) v = 8'h00;
        else if (MAXW != DEVW || lane == 0) v = ref_tbl(idx);
        else v = 8'h00;
      end else begin
        code = (idx % 256 == 0) ? K_MFR : (idx % 256 == 1) ? K_DEV : 16'h0000;
        v = 8'(code >> (8 * lane));
      end
      r[8*b +: 8] = v;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: present one read this cycle; the caller drops rd_stb when done
  task automatic issue(input bit tbl, input logic [1:0] lgw, input logic [AW-1:0] off,
                       input string tag);
    qry_mode = tbl;
    acc_lg   = lgw;
    byte_off = off;
    rd_stb   = 1'b1;
    exp_q.push_back(ref_data(tbl, lgw, off));
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: one result per valid, in strobe order
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected valid", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rsp_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(rsp_valid), 32'd0);
    check("R1 reset data", rsp_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 idle no valid", 32'(rsp_valid), 32'd0);

    // back-to-back strobes
    issue(1'b1, 2'd2, 16'h0040, "R9 R6 R7 table merge");
    issue(1'b1, 2'd0, 16'h0043, "R3 low offset bits ignored");
    issue(1'b1, 2'd1, 16'h0048, "R10 two-byte access");
    issue(1'b1, 2'd0, 16'h004C, "R5 command-set entry");
    issue(1'b1, 2'd2, 16'h0144, "R4 last entry then out of range");
    issue(1'b1, 2'd0, 16'h0148, "R4 out of range");
    issue(1'b1, 2'd2, 16'h009C, "R5 size entry");
    issue(1'b1, 2'd2, 16'h00A8, "R5 buffer entry");
    issue(1'b0, 2'd2, 16'h0000, "R8 R9 ident codes");
    issue(1'b0, 2'd1, 16'h0008, "R8 other index zero");
    issue(1'b0, 2'd0, 16'h0400, "R8 low index bits only");
    issue(1'b0, 2'd1, 16'h0404, "R8 R7 device code lanes");
    issue(1'b0, 2'd3, 16'h0004, "R10 size capped");
    rd_stb = 1'b0;
    repeat (3) @(negedge clk);

    // isolated strobe
    issue(1'b1, 2'd1, 16'h0044, "R2 isolated read");
    rd_stb = 1'b0;
    @(negedge clk);
    check("R2 valid drops after pulse", 32'(rsp_valid), 32'd0);
    repeat (2) @(negedge clk);
    check("R2 all results delivered", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule